// File: doc/BRIEF.md
# Indexed-Access SMBus Configuration Target

This block is the serial configuration port of a clock fan-out device. It answers on an SMBus segment and holds nine 8-bit configuration locations: the enable bits of 19 clock outputs, an 8-bit device code, a revision/vendor byte, three reserved locations and a count register. A host changes it with indexed block writes and inspects it with indexed block reads. The index is the number of a location. It steps up by one after each data byte. In a read, the byte after the read address is always the count register, and the locations follow from the stored index.

Two strap inputs each carry a three-level setting as a 2-bit code: 0 = low, 1 = mid, 2 or 3 = high. The pair selects one of nine target addresses. SCL and SDA are first brought into the system clock and filtered. The block drives SDA only by pulling it low, through `sda_pull`. While `ref_clk_ok` is low the port is inert. The port has no streaming interface: every pin is a plain level, and the only flow control is the SMBus acknowledge bit.

Top module: `smb_cfg_target`

## Requirements
- R1: The 8-bit write address is set by the straps as (hi,lo): (L,L)=D8h, (L,M)=DAh, (L,H)=DEh, (M,L)=C2h, (M,M)=C4h, (M,H)=C6h, (H,L)=CAh, (H,M)=CCh, (H,H)=CEh. Strap code 3 means high. The read address is the write address with bit 0 set. Any other address byte gets no acknowledge.
- R2: An indexed block write is start, write address, index N, count X, then data bytes. Each of these bytes is acknowledged. The first X data bytes go to locations N..N+X-1.
- R3: Data bytes that arrive after the X-th byte of a block write are acknowledged and discarded.
- R4: An indexed block read is start, write address, index N, repeated start, read address. The target then sends the count register byte, followed by locations N, N+1, and so on. It keeps sending until the host answers a byte with a not-acknowledge.
- R5: Location 8 is the count register. Bits 4:0 are writable, bits 7:5 read as 0, and the reset value is 08h.
- R6: Location 7 reads C3h. Location 5 reads {rev_id, 4'b0001}. Writes to either location have no effect.
- R7: Locations 3, 4 and 6 read as 00h. Bits 7:3 of location 0 read as 0. Indices 9 and above read as 00h. Writes to any of these have no effect.
- R8: `out_en[7:0]` is location 1 and `out_en[15:8]` is location 2. `out_en[18:16]` is bits 2:0 of location 0. Every enable bit resets to 1, and only a block write changes it.
- R9: A stop condition ends the transaction at any point. A data byte that is cut short by a stop is not stored.
- R10: While `ref_clk_ok` is low the target acknowledges nothing and never pulls SDA.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transaction.
- R12: The target changes `sda_pull` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_ok | input | 1 | High while the reference clock runs; enables the port |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_pull | output | 1 | 1 = pull SDA low |
| strap_hi | input | 2 | First address strap (0 low, 1 mid, 2/3 high) |
| strap_lo | input | 2 | Second address strap (0 low, 1 mid, 2/3 high) |
| rev_id | input | 4 | Revision code returned in location 5 |
| out_en | output | 19 | Per-output enable bits |

## Verification
A wrong bit counter or a wrong frame state shows at the ports within one byte time. It appears as an acknowledge on the wrong clock, a missing acknowledge, or read data shifted by one bit. A wrong index, a wrong write mask or a wrong count value first shows in the next read-back, or at once on `out_en`. For this reason every write in the sweep is followed by a full read of all locations. An SDA edge made during SCL high would be a false start or stop on the bus. The bench catches it in the same cycle, by watching `sda_pull` while the line is high.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_IDX, ST_IDX_ACK,
    ST_CNT, ST_CNT_ACK, ST_WDAT, ST_WDAT_ACK, ST_TX, ST_TX_ACK
  } link_st_t;

  localparam logic [7:0] IDX_REV   = 8'd5;
  localparam logic [7:0] IDX_DEV   = 8'd7;
  localparam logic [7:0] IDX_CNT   = 8'd8;
  localparam logic [7:0] DEV_CODE  = 8'hC3;
  localparam logic [3:0] VEND_CODE = 4'h1;
  localparam logic [4:0] CNT_INIT  = 5'd8;

  // strap code 3 is treated as high
  function automatic logic [1:0] lvl_norm(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  function automatic logic [7:0] target_addr(input logic [1:0] hi, input logic [1:0] lo);
    logic [3:0] k;
    k = {lvl_norm(hi), lvl_norm(lo)};
    case (k)
      4'b0000: return 8'hD8;
      4'b0001: return 8'hDA;
      4'b0010: return 8'hDE;
      4'b0100: return 8'hC2;
      4'b0101: return 8'hC4;
      4'b0110: return 8'hC6;
      4'b1000: return 8'hCA;
      4'b1001: return 8'hCC;
      default: return 8'hCE;
    endcase
  endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int  FILT_LEN = 3,
  parameter bit  RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      run_q  <= '0;
      dout   <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R11: the output only moves to a level the synchroniser already held
  p_filt_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(sync_q[1]) == dout));

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int N_OUT = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_idx,
  input  logic [3:0]       rev_id,
  output logic [7:0]       rd_data,
  output logic [7:0]       cnt_byte,
  output logic [N_OUT-1:0] out_en
);
  localparam int N_LOW = 16;

  // enables 0..7 -> location 1, 8..15 -> location 2, rest -> location 0
  function automatic logic [7:0] en_loc(input int b);
    return (b < 8) ? 8'd1 : (b < N_LOW) ? 8'd2 : 8'd0;
  endfunction

  function automatic int en_bit(input int b);
    return (b < N_LOW) ? (b % 8) : (b - N_LOW);
  endfunction

  logic [N_OUT-1:0] en_q;
  logic [4:0]       cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '1;
      cnt_q <= CNT_INIT;
    end else if (wr_en) begin
      for (int b = 0; b < N_OUT; b++) begin
        if (wr_idx == en_loc(b)) en_q[b] <= wr_data[en_bit(b)];
      end
      if (wr_idx == IDX_CNT) cnt_q <= wr_data[4:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < N_OUT; b++) begin
      if (rd_idx == en_loc(b)) rd_data[en_bit(b)] = en_q[b];
    end
    if (rd_idx == IDX_REV) rd_data = {rev_id, VEND_CODE};
    if (rd_idx == IDX_DEV) rd_data = DEV_CODE;
    if (rd_idx == IDX_CNT) rd_data = {3'b000, cnt_q};
  end

  assign cnt_byte = {3'b000, cnt_q};
  assign out_en   = en_q;

  // R8: enables move only on a write strobe
  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

  // R5: a count write lands its low five bits
  p_cnt_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_CNT) |=> (cnt_q == $past(wr_data[4:0])));

endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] my_addr,
  input  logic [7:0] cnt_byte,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  link_st_t   state;
  logic       scl_q, sda_q;
  logic [3:0] bitn;
  logic [7:0] shreg, idx, left;
  logic       rd_mode;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign rd_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bitn    <= '0;
      shreg   <= '0;
      idx     <= '0;
      left    <= '0;
      rd_mode <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (!active || stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_ADDR;
        bitn   <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_CNT, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              bitn  <= bitn + 1'b1;
            end else if (scl_fall && bitn == 4'd8) begin
              bitn <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[7:1] == my_addr[7:1]) begin
                    rd_mode <= shreg[0];
                    sda_oe  <= 1'b1;
                    state   <= ST_ADDR_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_IDX: begin
                  idx    <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_IDX_ACK;
                end
                ST_CNT: begin
                  left   <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_CNT_ACK;
                end
                default: begin
                  if (left != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= shreg;
                    idx     <= idx + 1'b1;
                    left    <= left - 1'b1;
                  end
                  sda_oe <= 1'b1;
                  state  <= ST_WDAT_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitn <= '0;
              if (rd_mode) begin
                shreg  <= cnt_byte;
                sda_oe <= ~cnt_byte[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDX;
              end
            end
          end
          ST_IDX_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_CNT;  end
          ST_CNT_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_WDAT; end
          ST_WDAT_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_WDAT; end
          ST_TX: begin
            if (scl_fall) begin
              if (bitn == 4'd7) begin
                bitn   <= '0;
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitn   <= bitn + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda_f) begin
              state <= ST_IDLE;
            end else if (scl_fall) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              idx    <= idx + 1'b1;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: no SDA movement while the filtered clock stays high
  p_sda_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_q) |-> $stable(sda_oe));

  // R10: the port goes quiet once the reference clock is lost
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sda_oe);

  // R2: register writes commit only in the SCL low phase
  p_wr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_f);

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter int N_OUT    = 19,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_ok,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull,
  input  logic [1:0]       strap_hi,
  input  logic [1:0]       strap_lo,
  input  logic [3:0]       rev_id,
  output logic [N_OUT-1:0] out_en
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic [7:0] rd_idx, rd_data, cnt_byte, wr_idx, wr_data;
  logic       wr_en;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    smb_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  smb_link u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (ref_clk_ok),
    .scl_f   (clean_lines[0]),
    .sda_f   (clean_lines[1]),
    .my_addr (target_addr(strap_hi, strap_lo)),
    .cnt_byte(cnt_byte),
    .rd_data (rd_data),
    .rd_idx  (rd_idx),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .sda_oe  (sda_pull)
  );

  smb_cfg_regs #(.N_OUT(N_OUT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rev_id  (rev_id),
    .rd_data (rd_data),
    .cnt_byte(cnt_byte),
    .out_en  (out_en)
  );

endmodule

// File: tb/smb_cfg_target_bench.sv
module smb_cfg_target_bench;
  localparam int H = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref_ok, scl_h, sda_h, glitch, glitch_en, sda_pull;
  logic [1:0] s_hi, s_lo;
  logic [3:0] rev;
  logic [18:0] out_en;
  wire scl_line = scl_h & ~glitch;
  wire sda_line = sda_h & ~sda_pull;

  smb_cfg_target u_smb_cfg_target (
    .clk(clk), .rst_n(rst_n), .ref_clk_ok(ref_ok), .scl_i(scl_line), .sda_i(sda_line),
    .sda_pull(sda_pull), .strap_hi(s_hi), .strap_lo(s_lo), .rev_id(rev), .out_en(out_en));

  int total = 0, bad = 0, viol = 0, off_pulls = 0;
  logic [7:0] mdl [0:8];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:15];
  logic [7:0] rcnt;
  bit acks_ok;
  logic scl_prev = 1'b1, pull_prev = 1'b0;

  // R12 / R10 line monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && scl_prev && (sda_pull != pull_prev)) viol++;
      if (!ref_ok && sda_pull) off_pulls++;
    end
    scl_prev  <= scl_line;
    pull_prev <= sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] addr_of(input int hi, input int lo);
    int h, l;
    h = (hi > 2) ? 2 : hi;
    l = (lo > 2) ? 2 : lo;
    case (h * 3 + l)
      0: return 8'hD8; 1: return 8'hDA; 2: return 8'hDE;
      3: return 8'hC2; 4: return 8'hC4; 5: return 8'hC6;
      6: return 8'hCA; 7: return 8'hCC; default: return 8'hCE;
    endcase
  endfunction

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0: return 8'h07; 1, 2: return 8'hFF; 8: return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    return (i <= 8) ? mdl[i] : 8'h00;
  endfunction

  task automatic model_write(input int i, input logic [7:0] d);
    if (i <= 8) mdl[i] = (mdl[i] & ~wmask(i)) | (d & wmask(i));
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_n(H); scl_h = 1'b1; wait_n(H);
    sda_h = 1'b0; wait_n(H); scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_n(H); scl_h = 1'b1; wait_n(H); sda_h = 1'b1; wait_n(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wait_n(H); scl_h = 1'b1;
      if (glitch_en) begin
        wait_n(H / 2); glitch = 1'b1; wait_n(1); glitch = 1'b0; wait_n(H - H / 2 - 1);
      end else wait_n(H);
      scl_h = 1'b0;
    end
    sda_h = 1'b1; wait_n(H); scl_h = 1'b1; wait_n(H / 2);
    ack = !sda_line; wait_n(H - H / 2); scl_h = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(H); scl_h = 1'b1; wait_n(H / 2); b[i] = sda_line; wait_n(H - H / 2); scl_h = 1'b0;
    end
    sda_h = !give_ack; wait_n(H); scl_h = 1'b1; wait_n(H); scl_h = 1'b0;
  endtask

  task automatic blk_write(input logic [7:0] a, input int n_idx, input int cnt, input int nsend);
    bit ak;
    acks_ok = 1'b1;
    bus_start();
    send_byte(a, ak); acks_ok &= ak;
    send_byte(8'(n_idx), ak); acks_ok &= ak;
    send_byte(8'(cnt), ak); acks_ok &= ak;
    for (int k = 0; k < nsend; k++) begin send_byte(wbuf[k], ak); acks_ok &= ak; end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] a, input int n_idx, input int n);
    bit ak;
    acks_ok = 1'b1;
    bus_start();
    send_byte(a, ak); acks_ok &= ak;
    send_byte(8'(n_idx), ak); acks_ok &= ak;
    bus_start();
    send_byte(a | 8'h01, ak); acks_ok &= ak;
    recv_byte(1'b1, rcnt);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic readback(input string tag);
    blk_read(8'hD8, 0, 9);
    chk(acks_ok, {tag, " R4 read acks"}, acks_ok, 1);
    chk(rcnt == mdl[8], {tag, " R5 count byte first"}, rcnt, mdl[8]);
    for (int i = 0; i < 9; i++)
      chk(rbuf[i] == mdl[i], $sformatf("%s R4/R6/R7 loc %0d", tag, i), rbuf[i], mdl[i]);
    chk(out_en == {mdl[0][2:0], mdl[2], mdl[1]}, {tag, " R8 out_en"}, out_en,
        {mdl[0][2:0], mdl[2], mdl[1]});
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait_n(190000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    bit ak;
    rst_n = 1'b0; ref_ok = 1'b1; scl_h = 1'b1; sda_h = 1'b1; glitch = 1'b0; glitch_en = 1'b0;
    s_hi = 2'd0; s_lo = 2'd0; rev = 4'hA;
    mdl[0] = 8'h07; mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[3] = 8'h00; mdl[4] = 8'h00;
    mdl[5] = {4'hA, 4'h1}; mdl[6] = 8'h00; mdl[7] = 8'hC3; mdl[8] = 8'h08;
    wait_n(10); rst_n = 1'b1; wait_n(10);

    chk(out_en == '1, "R8 reset enables", out_en, 19'h7FFFF);
    chk(!sda_pull, "R12 idle release", sda_pull, 0);
    readback("reset");

    // R2/R6/R7/R8: sweep of start index and count
    for (int n = 0; n < 9; n++) begin
      for (int c = 1; c <= 2; c++) begin
        for (int k = 0; k < c; k++) wbuf[k] = 8'((n * 29 + k * 53 + c * 7 + 3) & 8'hFF);
        blk_write(8'hD8, n, c, c);
        chk(acks_ok, $sformatf("R2 write acks n=%0d", n), acks_ok, 1);
        for (int k = 0; k < c; k++) model_write(n + k, wbuf[k]);
        readback("R2 sweep");
      end
    end

    // R3: extra bytes beyond count are dropped
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h96;
    blk_write(8'hD8, 1, 1, 3);
    chk(acks_ok, "R3 extra bytes acked", acks_ok, 1);
    model_write(1, 8'h3C);
    readback("R3");

    // R7: read past the last location
    blk_read(8'hD8, 6, 6);
    for (int k = 0; k < 6; k++)
      chk(rbuf[k] == exp_rd(6 + k), $sformatf("R7 index %0d", 6 + k), rbuf[k], exp_rd(6 + k));

    // R9: stop in the middle of a data byte
    bus_start();
    send_byte(8'hD8, ak); send_byte(8'd1, ak); send_byte(8'd1, ak);
    for (int i = 0; i < 4; i++) begin
      sda_h = 1'b0; wait_n(H); scl_h = 1'b1; wait_n(H); scl_h = 1'b0;
    end
    bus_stop();
    readback("R9 abort");

    // R11: short low pulses on SCL while high
    glitch_en = 1'b1;
    wbuf[0] = 8'h5A;
    blk_write(8'hD8, 2, 1, 1);
    glitch_en = 1'b0;
    chk(acks_ok, "R11 acks under glitches", acks_ok, 1);
    model_write(2, 8'h5A);
    readback("R11");

    // R10: reference clock missing
    ref_ok = 1'b0; wait_n(4);
    bus_start(); send_byte(8'hD8, ak); bus_stop();
    chk(!ak, "R10 no ack when off", ak, 0);
    chk(off_pulls == 0, "R10 no pull when off", off_pulls, 0);
    ref_ok = 1'b1; wait_n(4);

    // R1: strap decode, each setting probed with all nine addresses
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        if ((h == 3) != (l == 3)) continue;
        s_hi = 2'(h); s_lo = 2'(l); wait_n(4);
        for (int p = 0; p < 9; p++) begin
          bus_start(); send_byte(addr_of(p / 3, p % 3), ak); bus_stop();
          chk(ak == (addr_of(p / 3, p % 3) == addr_of(h, l)),
              $sformatf("R1 straps %0d/%0d probe %0h", h, l, addr_of(p / 3, p % 3)),
              ak, addr_of(p / 3, p % 3) == addr_of(h, l));
        end
      end
    end
    s_hi = 2'd1; s_lo = 2'd2; wait_n(4);
    blk_read(8'hC6, 7, 1);
    chk(acks_ok && rbuf[0] == 8'hC3, "R1 read address C7", rbuf[0], 8'hC3);

    chk(viol == 0, "R12 sda_pull steady while SCL high", viol, 0);
    report();
  end

endmodule